// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block turns a watchdog timeout into a reset pulse on an external pad. The pulse length comes from a duration field held in a control register. The pulse is timed against a 1 MHz tick, so the field counts microseconds. A field value of N gives a pulse that spans N+1 ticks. The pulse is issued only when the external-signal enable input is high.

The same register holds two pad settings: the polarity (active-high or active-low) and the drive style (push-pull or open-drain). These two bits are guarded. Each one changes only when a specific key byte is written in the top byte of the register. A write with any other top byte still updates the duration field but leaves both pad bits as they were.

The pad interface has two outputs, a data value and an output-enable, so the same block can drive a push-pull pin or an open-drain pin.

Top module: `xrst_pulse_gen`

## Requirements
- R1: After reset, the register at address 0x18 reads 0x000000FF: duration 0xFF, active-low, open-drain. The pad is released (pad_oe=0). The first pulse after reset spans 256 ticks.
- R2: A write to address 0x18 loads the duration field from write-data bits DUR_W-1:0, where DUR_W is 20 in the wide variant (default) and 8 in the narrow variant. A write to any other address changes nothing.
- R3: Writing top byte (bits 31:24) 0xA5 sets active-high polarity. Writing 0x5A sets active-low polarity.
- R4: Writing top byte 0xA8 selects push-pull drive. Writing 0x8A selects open-drain drive. The polarity bit is kept.
- R5: Any other top byte leaves the polarity and drive bits unchanged, and the duration field is still loaded.
- R6: A read of address 0x18 returns bit 31 = polarity (1 = active-high), bit 30 = drive (1 = push-pull), the duration field in its low bits, and zero elsewhere. A read of any other address returns 0.
- R7: A timeout trigger seen in a clock cycle with the enable high and no pulse running starts a pulse on the next clock edge. The pulse stays asserted for exactly N+1 tick cycles, where N is the duration field.
- R8: A trigger with the enable low produces no pulse.
- R9: A trigger that arrives while a pulse is running is ignored. The running pulse ends on its original schedule.
- R10: In open-drain mode, pad_oe is high only while the pulse is asserted, and pad_data then holds the active level (1 if active-high, 0 if active-low). In push-pull mode, pad_oe is always high, and pad_data is the active level during the pulse and its inverse otherwise.
- R11: The duration is captured when the pulse starts. A register write during a pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle strobe every microsecond |
| wdt_timeout | input | 1 | Timeout trigger from the watchdog counter |
| ext_sig_en | input | 1 | Enables the external pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pad_data | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output-enable |

## Verification
Timing of each result:
- A register write takes effect at the clock edge that samples it. Read data is combinational, so the bench reads back half a cycle after the write edge.
- A trigger raises the pulse at the clock edge that samples it. The pad outputs follow that edge combinationally.

How the checks keep to that timing:
- The bench drives stimulus on the falling edge and samples on the falling edge.
- The monitor counts the ticks present in the cycles where the pad shows the active level. When the pulse ends, it compares that count with the N+1 value queued by the driver.
- A pulse that the monitor sees while nothing is queued is reported as a failure. This is how the ignored triggers are checked.

// File: rtl/xrp_pkg.sv
package xrp_pkg;
  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD   = 8'h8A;
  localparam logic [7:0] REG_WIDTH_ADDR = 8'h18;

  typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} pol_e;
  typedef enum logic {DRV_OD = 1'b0, DRV_PP = 1'b1} drv_e;

  typedef struct packed {
    pol_e pol;
    drv_e drv;
  } padcfg_t;
endpackage

// File: rtl/xrp_cfg_reg.sv
module xrp_cfg_reg
  import xrp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DUR_W  = 20,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(REG_WIDTH_ADDR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DUR_W-1:0]  dur_o,
  output padcfg_t           padcfg_o
);
  localparam int GAP_W = DATA_W - 2 - DUR_W;
  localparam logic [DUR_W-1:0] DUR_RST = DUR_W'(8'hFF);

  logic [DUR_W-1:0] dur_q, dur_d;
  padcfg_t          cfg_q, cfg_d;
  logic             hit;
  logic [7:0]       key;

  assign hit = (addr == REG_ADDR);
  assign key = wr_data[DATA_W-1 -: 8];

  // Next-state logic: the duration field always loads on a write hit,
  // while the pad bits load only on their own key byte.
  always_comb begin
    dur_d = dur_q;
    cfg_d = cfg_q;
    if (wr_en && hit) begin
      dur_d = wr_data[DUR_W-1:0];
      case (key)
        KEY_POL_HIGH: cfg_d.pol = POL_HIGH;
        KEY_POL_LOW:  cfg_d.pol = POL_LOW;
        KEY_DRV_PP:   cfg_d.drv = DRV_PP;
        KEY_DRV_OD:   cfg_d.drv = DRV_OD;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q     <= DUR_RST;
      cfg_q.pol <= POL_LOW;
      cfg_q.drv <= DRV_OD;
    end else begin
      dur_q <= dur_d;
      cfg_q <= cfg_d;
    end
  end

  assign rd_data  = hit ? {cfg_q.pol, cfg_q.drv, {GAP_W{1'b0}}, dur_q} : '0;
  assign dur_o    = dur_q;
  assign padcfg_o = cfg_q;

  p_pol_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && key == KEY_POL_HIGH) |=> (padcfg_o.pol == POL_HIGH));
  p_pol_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && key == KEY_POL_LOW) |=> (padcfg_o.pol == POL_LOW));
  p_drv_pp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && key == KEY_DRV_PP) |=> (padcfg_o.drv == DRV_PP));
  p_other_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && key != KEY_POL_HIGH && key != KEY_POL_LOW &&
     key != KEY_DRV_PP && key != KEY_DRV_OD) |=> $stable(padcfg_o));
  p_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && hit)) |=> ($stable(dur_o) && $stable(padcfg_o)));
endmodule

// File: rtl/xrp_pulse_timer.sv
module xrp_pulse_timer #(
  parameter int DUR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig,
  input  logic             ext_en,
  input  logic [DUR_W-1:0] dur_i,
  output logic             busy_o
);
  logic             busy_q, busy_d;
  logic [DUR_W-1:0] cnt_q, cnt_d;

  // Next-state logic: a pulse starts only from idle, and then runs
  // for the captured count plus one tick.
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (trig && ext_en) begin
        busy_d = 1'b1;
        cnt_d  = dur_i;
      end
    end else if (tick) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && trig && ext_en) |=> (busy_q && cnt_q == $past(dur_i)));
  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick && cnt_q == '0) |=> !busy_q);
  p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !(trig && ext_en)) |=> !busy_q);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> (busy_q && $stable(cnt_q)));
endmodule

// File: rtl/xrp_pad_drv.sv
module xrp_pad_drv
  import xrp_pkg::*;
(
  input  logic    asserted,
  input  padcfg_t padcfg,
  output logic    pad_data,
  output logic    pad_oe
);
  logic act_lvl;
  assign act_lvl = (padcfg.pol == POL_HIGH);

  always_comb begin
    if (padcfg.drv == DRV_PP) begin
      pad_oe   = 1'b1;
      pad_data = asserted ? act_lvl : ~act_lvl;
    end else begin
      pad_oe   = asserted;
      pad_data = act_lvl;
    end
  end
endmodule

// File: rtl/xrst_pulse_gen.sv
module xrst_pulse_gen
  import xrp_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter bit WIDE_FIELD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              wdt_timeout,
  input  logic              ext_sig_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pad_data,
  output logic              pad_oe
);
  localparam int DUR_W = WIDE_FIELD ? 20 : 8;

  logic [DUR_W-1:0] dur;
  padcfg_t          padcfg;
  logic             busy;

  xrp_cfg_reg #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DUR_W(DUR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .dur_o(dur), .padcfg_o(padcfg)
  );

  xrp_pulse_timer #(.DUR_W(DUR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_1us), .trig(wdt_timeout),
    .ext_en(ext_sig_en), .dur_i(dur), .busy_o(busy)
  );

  xrp_pad_drv u_pad (
    .asserted(busy), .padcfg(padcfg), .pad_data(pad_data), .pad_oe(pad_oe)
  );

  p_od_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (padcfg.drv == DRV_OD && !busy) |-> !pad_oe);
  p_pp_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (padcfg.drv == DRV_PP) |-> pad_oe);
endmodule

// File: tb/test_xrst_pulse_gen.sv
module test_xrst_pulse_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1us = 1'b0;
  logic        wdt_timeout = 1'b0;
  logic        ext_sig_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h18;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pad_data, pad_oe;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  bit m_pol = 1'b0;
  bit m_pp = 1'b0;
  bit act_prev = 1'b0;
  int tick_cnt = 0;
  int tdiv = 0;

  xrst_pulse_gen i_xrst_pulse_gen (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .wdt_timeout(wdt_timeout),
    .ext_sig_en(ext_sig_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_data(pad_data), .pad_oe(pad_oe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #1;
    tdiv = (tdiv + 1) % 4;
    tick_1us = (tdiv == 0);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: measure each pulse in ticks and compare against the scoreboard.
  always @(negedge clk) begin
    bit act;
    if (!rst_n) begin
      act_prev = 1'b0;
      tick_cnt = 0;
    end else begin
      act = m_pp ? (pad_data == m_pol) : pad_oe;
      if (act && !act_prev) begin
        tick_cnt = 0;
        if (exp_q.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R8/R9 unexpected pulse actual=1 expected=0");
        end
      end
      if (act && tick_1us) tick_cnt++;
      if (!act && act_prev && exp_q.size() != 0) begin
        int e;
        e = exp_q.pop_front();
        chk("R7 pulse length in ticks", tick_cnt, e);
      end
      act_prev = act;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    if (a == 8'h18) begin
      case (d[31:24])
        8'hA5: m_pol = 1'b1;
        8'h5A: m_pol = 1'b0;
        8'hA8: m_pp = 1'b1;
        8'h8A: m_pp = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    reg_addr = 8'h18;
  endtask

  task automatic fire(bit en, int exp_len);
    if (exp_len > 0) exp_q.push_back(exp_len);
    @(negedge clk);
    wdt_timeout = 1'b1; ext_sig_en = en;
    @(posedge clk);
    #1;
    wdt_timeout = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || act_prev) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_pol = 1'b0; m_pp = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd("R1 reset register value", 8'h18, 32'h000000FF);
    chk("R1 pad released after reset", {31'd0, pad_oe}, 32'd0);

    // R2 / R6 field load and address decode
    wr(8'h18, 32'h00000003);
    rd("R2 duration field load", 8'h18, 32'h00000003);
    wr(8'h1C, 32'hA5000005);
    rd("R2 other address write ignored", 8'h18, 32'h00000003);
    rd("R6 other address reads zero", 8'h1C, 32'h00000000);
    wr(8'h18, 32'h00F12345);
    rd("R5 plain write loads 20-bit field", 8'h18, 32'h00012345);

    // R3 / R4 / R5 key bytes
    wr(8'h18, 32'hA5000004);
    rd("R3 key A5 sets active-high", 8'h18, 32'h80000004);
    wr(8'h18, 32'h77000006);
    rd("R5 other key keeps pad bits", 8'h18, 32'h80000006);
    wr(8'h18, 32'hA8000002);
    rd("R4 key A8 push-pull, polarity kept", 8'h18, 32'hC0000002);
    wr(8'h18, 32'h8A000002);
    rd("R4 key 8A open-drain", 8'h18, 32'h80000002);
    wr(8'h18, 32'h5A000003);
    rd("R3 key 5A sets active-low", 8'h18, 32'h00000003);

    // R7 / R10 open-drain active-low pulse of 3+1 ticks
    fire(1'b1, 4);
    @(negedge clk);
    chk("R10 open-drain drives during pulse", {30'd0, pad_oe, pad_data}, 32'h2);
    wait_idle();
    chk("R10 open-drain released after pulse", {31'd0, pad_oe}, 32'd0);

    // R8 disabled trigger
    fire(1'b0, 0);
    repeat (20) @(negedge clk);
    chk("R8 no drive with enable low", {31'd0, pad_oe}, 32'd0);

    // R9 retrigger ignored
    wr(8'h18, 32'h00000005);
    fire(1'b1, 6);
    repeat (6) @(negedge clk);
    fire(1'b1, 0);
    wait_idle();

    // R7 zero duration gives one tick
    wr(8'h18, 32'h00000000);
    fire(1'b1, 1);
    wait_idle();

    // R10 push-pull active-high
    wr(8'h18, 32'hA5000002);
    wr(8'h18, 32'hA8000002);
    @(negedge clk);
    chk("R10 push-pull idle level", {30'd0, pad_oe, pad_data}, 32'h2);
    fire(1'b1, 3);
    @(negedge clk);
    chk("R10 push-pull active level", {30'd0, pad_oe, pad_data}, 32'h3);
    wait_idle();

    // R11 write during pulse does not change its length
    wr(8'h18, 32'h00000006);
    fire(1'b1, 7);
    repeat (3) @(negedge clk);
    wr(8'h18, 32'h00000001);
    wait_idle();
    rd("R11 new field value stored", 8'h18, 32'hC0000001);

    // R1 default duration gives 256 ticks
    do_reset();
    fire(1'b1, 256);
    wait_idle();

    chk("R7 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule